// File: doc/BRIEF.md
# Three-Channel Phase-Shifted Carrier Sinusoidal PWM Generator

The block drives three PWM channels that share one sinusoidal modulation. Each channel runs its own up-counting sawtooth carrier, and the carriers of channels 1 and 2 lag channel 0 by a fixed number of ticks. The carriers are shifted, not the sine reference. Each channel has two outputs. One carries the pulses for the positive half of the sine wave. The other carries the pulses for the negative half. The output that is not in use stays low.

A constant half-sine duty table is built at elaboration. A sine index steps once per channel-0 carrier period and wraps after a full sine cycle. Each new set of compare values passes through one shared shadow register. A channel copies it only when its own carrier returns to zero, so no channel changes its pulse width in the middle of a carrier period. The only controls are a synchronous reset and an enable that freezes the whole block.

Top module: `spwm_pshift_top`

## Requirements
- R1: When `rst` is high at a clock edge, all six outputs are driven low and every carrier and the sine index are cleared. The outputs stay low until the first edge with `en` high.
- R2: At an edge with `en` low, all carriers and the index hold their values and all six outputs go low after that edge. The next enabled edge carries on from the held state.
- R3: Carriers count 0 to PERIOD−1. Define D(i) = trunc(sin(2π·i/STEPS)·PERIOD) for i from 0 to STEPS/2−1. In a carrier period that uses index n, the modulated output is high exactly on the ticks where the carrier count c satisfies c ≥ PERIOD − D(n mod STEPS/2). These are the last D ticks of the period.
- R4: If the index is below STEPS/2, `pwm_pos[k]` is modulated and `pwm_neg[k]` is low for the whole period. Otherwise `pwm_neg[k]` is modulated with D(index − STEPS/2) and `pwm_pos[k]` is low.
- R5: The idle output of a channel stays low for the whole period, including periods where the modulated output has a compare of zero and is high for all of it (the sine peak).
- R6: Counted in enabled ticks from the first enabled edge, channel k's carrier lags channel 0 by k·PHASE_TICKS. Channel k's outputs stay low until its carrier first reaches zero. Rising edges of matching pulses on channel k and channel 0 are exactly k·PHASE_TICKS enabled ticks apart.
- R7: The carrier period p of channel 0 (counted from 0) uses index p mod STEPS, so the sine sequence repeats after STEPS periods.
- R8: A channel takes a new compare value and half selection only when its own carrier returns to zero. A lagging channel's period uses the index of the channel-0 period that began k·PHASE_TICKS ticks earlier, even after channel 0 has moved on to the next index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one carrier tick per enabled edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances carriers and index when high; freezes them and forces outputs low when low |
| pwm_pos | output | CHANNELS | Positive-half PWM output, one bit per channel |
| pwm_neg | output | CHANNELS | Negative-half PWM output, one bit per channel |

## Verification
The hardest window to reach is the few ticks right after channel 0 wraps. In that window a lagging channel is still finishing its previous period while the shared shadow register already holds the next index. The window only matters if the bench watches long enough to cross both half-wave boundaries and the sine wrap. The stimulus therefore runs a shortened carrier and table through more than one full sine cycle, with enable randomly dropped. Every tick, the bench checks all six outputs against a model that works in enabled-tick time, so each pause also lands at an arbitrary carrier phase. A directed reset in mid-run confirms that the channel spacing restarts cleanly.

// File: rtl/spwm_pkg.sv
`timescale 1ns/1ps
package spwm_pkg;
    // compare bus width shared between the index sequencer and the channels
    localparam int unsigned CMP_W = 16;
    localparam real TWO_PI = 6.283185307179586;

    typedef struct packed {
        logic             neg_half;
        logic [CMP_W-1:0] cmp;
    } shadow_t;

    // carrier value loaded on the first enabled cycle so that the carrier
    // reaches zero exactly `lag` ticks after channel 0 does
    function automatic int unsigned carrier_init(int unsigned period, int unsigned lag);
        int unsigned m;
        m = lag % period;
        return (m == 0) ? 0 : period - m;
    endfunction
endpackage

// File: rtl/spwm_duty_rom.sv
`timescale 1ns/1ps
module spwm_duty_rom #(
    parameter  int unsigned PERIOD = 168,
    parameter  int unsigned STEPS  = 5000,
    localparam int unsigned HALF   = STEPS / 2,
    localparam int unsigned AW     = $clog2(HALF),
    localparam int unsigned DW     = $clog2(PERIOD + 1)
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] duty
);
    logic [DW-1:0] rom [HALF];

    // half-sine table, truncated toward zero, built at elaboration
    for (genvar g = 0; g < HALF; g++) begin : g_ent
        localparam real ANG = spwm_pkg::TWO_PI * real'(g) / real'(STEPS);
        localparam int  VAL = $rtoi($sin(ANG) * real'(PERIOD));
        assign rom[g] = DW'(VAL);
    end

    assign duty = rom[addr];
endmodule

// File: rtl/spwm_index_seq.sv
`timescale 1ns/1ps
module spwm_index_seq #(
    parameter  int unsigned PERIOD = 168,
    parameter  int unsigned STEPS  = 5000,
    localparam int unsigned HALF   = STEPS / 2,
    localparam int unsigned IW     = $clog2(STEPS),
    localparam int unsigned AW     = $clog2(HALF),
    localparam int unsigned DW     = $clog2(PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    output spwm_pkg::shadow_t shadow_d_o,
    output logic              started_o
);
    import spwm_pkg::*;

    typedef struct packed {
        logic [IW-1:0] idx;
        shadow_t       shadow;
        logic          started;
    } seq_t;

    localparam seq_t SEQ_RST = '{idx: '0, shadow: '{neg_half: 1'b0, cmp: CMP_W'(PERIOD)}, started: 1'b0};

    seq_t          seq_q, seq_d;
    logic [AW-1:0] rom_addr;
    logic [DW-1:0] rom_duty;
    logic          in_neg;

    spwm_duty_rom #(.PERIOD(PERIOD), .STEPS(STEPS)) u_rom (
        .addr (rom_addr),
        .duty (rom_duty)
    );

    always_comb begin
        seq_d         = seq_q;
        seq_d.started = seq_q.started | en;
        in_neg        = (32'(seq_q.idx) >= HALF);
        rom_addr      = in_neg ? AW'(32'(seq_q.idx) - HALF) : AW'(seq_q.idx);
        if (tick) begin
            seq_d.shadow.cmp      = CMP_W'(PERIOD) - CMP_W'(rom_duty);
            seq_d.shadow.neg_half = in_neg;
            seq_d.idx             = (32'(seq_q.idx) == STEPS - 1) ? '0 : seq_q.idx + IW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= SEQ_RST;
        else     seq_q <= seq_d;
    end

    assign shadow_d_o = seq_d.shadow;
    assign started_o  = seq_q.started;

    assert_idx_range_R7: assert property (@(posedge clk) disable iff (rst)
        32'(seq_q.idx) < STEPS);
    assert_shadow_cmp_R3: assert property (@(posedge clk) disable iff (rst)
        32'(seq_q.shadow.cmp) <= PERIOD);
    assert_idx_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(seq_q.idx));
endmodule

// File: rtl/spwm_carrier_ch.sv
`timescale 1ns/1ps
module spwm_carrier_ch #(
    parameter  int unsigned PERIOD = 168,
    parameter  int unsigned INIT   = 0,
    localparam int unsigned CW     = $clog2(PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              start,
    input  spwm_pkg::shadow_t shadow_in,
    output logic              wrap_o,
    output logic [CW-1:0]     cnt_o,
    output logic              pos_o,
    output logic              neg_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] cmp;
        logic          neg_sel;
        logic          pos;
        logic          neg;
    } ch_t;

    localparam ch_t CH_RST = '{cnt: '0, cmp: CW'(PERIOD), neg_sel: 1'b0, pos: 1'b0, neg: 1'b0};

    ch_t  ch_q, ch_d;
    logic hit;

    always_comb begin
        ch_d = ch_q;
        if (start)
            ch_d.cnt = CW'(INIT);
        else if (run)
            ch_d.cnt = (ch_q.cnt == CW'(PERIOD - 1)) ? '0 : ch_q.cnt + CW'(1);
        wrap_o = run && (ch_d.cnt == '0);
        if (wrap_o) begin
            ch_d.cmp     = CW'(shadow_in.cmp);
            ch_d.neg_sel = shadow_in.neg_half;
        end
        hit         = run && (ch_d.cnt >= ch_d.cmp);
        ch_d.pos    = hit && !ch_d.neg_sel;
        ch_d.neg    = hit && ch_d.neg_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) ch_q <= CH_RST;
        else     ch_q <= ch_d;
    end

    assign cnt_o = ch_q.cnt;
    assign pos_o = ch_q.pos;
    assign neg_o = ch_q.neg;

    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
        32'(ch_q.cnt) < PERIOD);
    assert_cmp_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (ch_q.cnt != '0) |-> $stable(ch_q.cmp));
    assert_one_side_R4: assert property (@(posedge clk) disable iff (rst)
        !(ch_q.pos && ch_q.neg));
    assert_pause_low_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!ch_q.pos && !ch_q.neg));
    assert_rise_after_cmp_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(ch_q.pos) || $rose(ch_q.neg)) |-> (ch_q.cnt >= ch_q.cmp));
endmodule

// File: rtl/spwm_pshift_top.sv
`timescale 1ns/1ps
module spwm_pshift_top #(
    parameter  int unsigned PERIOD      = 168,
    parameter  int unsigned STEPS       = 5000,
    parameter  int unsigned PHASE_TICKS = 28,
    parameter  int unsigned CHANNELS    = 3,
    localparam int unsigned CW          = $clog2(PERIOD + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    output logic [CHANNELS-1:0] pwm_pos,
    output logic [CHANNELS-1:0] pwm_neg
);
    import spwm_pkg::*;

    shadow_t               shadow_d;
    logic                  started;
    logic                  start;
    logic [CHANNELS-1:0]   wrap;
    logic [CW-1:0]         cnt [CHANNELS];

    assign start = en && !started;

    spwm_index_seq #(.PERIOD(PERIOD), .STEPS(STEPS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .tick       (wrap[0]),
        .shadow_d_o (shadow_d),
        .started_o  (started)
    );

    for (genvar k = 0; k < CHANNELS; k++) begin : g_ch
        localparam int unsigned LAG = k * PHASE_TICKS;

        spwm_carrier_ch #(
            .PERIOD (PERIOD),
            .INIT   (carrier_init(PERIOD, LAG))
        ) u_ch (
            .clk       (clk),
            .rst       (rst),
            .run       (en),
            .start     (start),
            .shadow_in (shadow_d),
            .wrap_o    (wrap[k]),
            .cnt_o     (cnt[k]),
            .pos_o     (pwm_pos[k]),
            .neg_o     (pwm_neg[k])
        );

        if (k > 0) begin : g_lag_chk
            assert_carrier_lag_R6: assert property (@(posedge clk) disable iff (rst)
                started |-> (((int'(cnt[0]) + int'(PERIOD) - int'(cnt[k])) % int'(PERIOD))
                             == int'(LAG % PERIOD)));
        end
    end
endmodule

// File: tb/tb_spwm_pshift_top.sv
`timescale 1ns/1ps
module tb_spwm_pshift_top;
    localparam int P  = 48;
    localparam int S  = 200;
    localparam int H  = S / 2;
    localparam int PH = 8;
    localparam int NC = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [NC-1:0] pos, neg;

    always #2 clk = ~clk;

    spwm_pshift_top #(.PERIOD(P), .STEPS(S), .PHASE_TICKS(PH), .CHANNELS(NC)) dut (
        .clk (clk), .rst (rst), .en (en), .pwm_pos (pos), .pwm_neg (neg)
    );

    int n_run = 0, n_fail = 0;
    int a = 0;                 // enabled edges since reset
    bit rst_prev = 1'b1, en_prev = 1'b0, done = 1'b0;
    bit prev_o [NC][2];
    int last0 [2];
    bit v0 [2];

    function automatic int duty(int i);
        return $rtoi($sin(6.283185307179586 * real'(i) / real'(S)) * real'(P));
    endfunction

    task automatic check_bit(logic got, bit exp, string req, string what);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b (tick %0d)", req, what, got, exp, a);
        end
    endtask

    task automatic check_int(int got, int exp, string req, string what);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (tick %0d)", req, what, got, exp, a);
        end
    endtask

    task automatic check_all();
        for (int k = 0; k < NC; k++) begin
            for (int o = 0; o < 2; o++) begin
                bit    exp;
                string req;
                logic  got;
                got = (o == 1) ? neg[k] : pos[k];
                exp = 1'b0;
                if (rst_prev) req = "R1";
                else if (!en_prev) req = (a == 0) ? "R1" : "R2";
                else begin
                    int t;
                    t = a - 1 - k * PH;
                    if (t < 0) req = "R6";
                    else begin
                        int p, ph, idx, e;
                        bit half, active;
                        p      = t / P;
                        ph     = t % P;
                        idx    = p % S;
                        half   = (idx >= H);
                        e      = duty(half ? idx - H : idx);
                        active = (half == (o == 1));
                        exp    = active && (ph >= P - e);
                        if (!active) req = (idx == S / 4) ? "R5" : "R4";
                        else if (p >= S) req = "R7";
                        else if (k > 0 && ((a - 1) % P) < k * PH) req = "R8";
                        else req = "R3";
                    end
                end
                check_bit(got, exp, req, $sformatf("ch%0d %s", k, (o == 1) ? "neg" : "pos"));
            end
        end
        // rising-edge spacing in enabled-tick time
        if (rst_prev) begin
            for (int k = 0; k < NC; k++) begin prev_o[k][0] = 0; prev_o[k][1] = 0; end
            v0[0] = 0; v0[1] = 0;
        end else if (en_prev && a > 0) begin
            for (int k = 0; k < NC; k++) begin
                for (int o = 0; o < 2; o++) begin
                    bit cur;
                    cur = (o == 1) ? neg[k] : pos[k];
                    if (cur && !prev_o[k][o]) begin
                        if (k == 0) begin last0[o] = a; v0[o] = 1'b1; end
                        else if (v0[o]) check_int(a - last0[o], k * PH, "R6",
                                                  $sformatf("edge gap ch%0d side %0d", k, o));
                    end
                    prev_o[k][o] = cur;
                end
            end
        end
    endtask

    task automatic cycle(bit r, bit e);
        @(negedge clk);
        check_all();
        rst = r; en = e;
        rst_prev = r; en_prev = e;
        if (r) a = 0;
        else if (e) a++;
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd7341);
        repeat (4) cycle(1'b1, 1'b1);             // R1: reset dominates enable
        repeat (5) cycle(1'b0, 1'b0);             // R1: idle before first enable
        while (a < (S + 2) * P + 2 * PH + 4)      // R7: run past one full sine cycle
            cycle(1'b0, $urandom_range(9, 0) != 0);
        repeat (3) cycle(1'b1, 1'b1);             // R1: reset in mid-run
        repeat (4 * P) cycle(1'b0, 1'b1);         // R6: spacing restarts cleanly
        cycle(1'b0, 1'b0);
        cycle(1'b0, 1'b0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired (all requirements)");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule